// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One 16-bit down-counting channel of a classic interval timer. The channel advances only on cycles where the count-enable tick is high. A separate register block owns the bus, the byte sequencing and the latching. It hands this channel a single-cycle load strobe carrying an initial count, a 3-bit operating mode and a BCD select.

The channel drives two outputs. The live count comes straight from its counter register, so the register block can latch it without a further cycle of delay. The OUT waveform is shaped by the selected mode.

The six modes are:
- an interrupt-on-terminal-count level
- a retriggerable one-shot
- a rate generator
- a square wave
- a gate-paused software strobe
- a gate-retriggered hardware strobe

An initial count of zero stands for the largest count. Non-periodic modes wrap and keep counting; periodic modes reload.

Top module: `pit_channel`

## Requirements
- R1: After reset `count_o` is 0 and `out_o` is low, and neither changes, whatever the tick and gate inputs do, until the first load.
- R2: Mode codes 6 and 7 behave exactly as modes 2 and 3; codes 0..5 select modes 0..5.
- R3: A loaded count of 0 counts as 65536 ticks in binary and 10000 in BCD. In modes 0, 1, 4 and 5 the counter passes 0 and continues from FFFF hex (binary) or 9999 (BCD).
- R4: Mode 0: OUT is low after load and goes high on the tick that brings the elapsed count to the initial count N. It stays high until the next load. Ticks are counted only while the gate is high.
- R5: Mode 1: OUT is high after load and goes low on the N-th tick. A gate rising edge reloads N and sets OUT high again. The gate level does not pause counting.
- R6: Mode 2: the count runs N, N-1 .. 1 and reloads N on the tick after 1. OUT is high for exactly the tick interval following each reload, and is low after the load itself.
- R7: Mode 3, for N of 2 or more: the count drops by two per tick. OUT is high for (N+1)/2 ticks, rounded down, and then low for N/2 ticks, rounded down, each period. At the start of each high phase the count shows N rounded up to even; at the start of each low phase it shows N rounded down to even. The BCD select is ignored in this mode.
- R8: Mode 4: OUT rises on the N-th counted tick and falls on the next counted tick, once per load. Ticks are counted only while the gate is high.
- R9: Mode 5: like mode 4, except that the gate level does not pause counting, and a gate rising edge reloads N and re-arms the strobe.
- R10: The count changes only on a tick, a load, or a gate rising edge in modes 1, 2, 3 and 5. A load takes priority over both: on the cycle after the strobe the count shows the new value (in mode 3, rounded up to even) and elapsed ticks restart from zero.
- R11: In BCD mode each 4-bit digit decrements as a decimal digit, borrowing from the next digit when it passes 0 (for example 0100 becomes 0099).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable tick |
| gate_i | input | 1 | Gate input (level or rising edge, depending on mode) |
| load_i | input | 1 | Single-cycle strobe that loads count, mode and BCD select |
| load_count_i | input | 16 | Initial count, where 0 means the maximum count |
| load_mode_i | input | 3 | Operating mode code |
| load_bcd_i | input | 1 | 1 selects BCD counting |
| count_o | output | 16 | Live counter value |
| out_o | output | 1 | Mode-shaped OUT signal |

## Verification
The digit-range property assumes the register block only loads valid BCD values when BCD is selected. Every BCD load in the stimulus uses decimal digits.

The gate-related properties assume that a gate rise is judged against the gate value one clock earlier. The stimulus therefore changes the gate only between clock edges, and at most once per cycle.

Mode 3 is exercised only with counts of two or more, because a count of one has no defined square wave.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned DIGITS = CNT_W / 4;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_TC_INT  = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SW_STB  = 3'd4,
    M_HW_STB  = 3'd5
  } pit_mode_e;

  // codes 6 and 7 alias the periodic modes
  function automatic pit_mode_e norm_mode(logic [MODE_W-1:0] m);
    return pit_mode_e'((m > 3'd5) ? m - 3'd4 : m);
  endfunction

  function automatic logic [CNT_W-1:0] bcd_dec(logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (borrow) begin
        if (v[4*i +: 4] == 4'd0) begin
          r[4*i +: 4] = 4'd9;
        end else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_edge_det.sv
module pit_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             rise_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  pit_mode_e        load_mode_i,
  input  logic             load_bcd_i,
  output logic [CNT_W-1:0] cnt_o,
  output pit_mode_e        mode_o,
  output logic             bcd_o,
  output logic             live_o,
  output logic             sq_hi_o,
  output logic             run_o,
  output logic             restart_o,
  output logic             at_one_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, init_q;
  pit_mode_e        mode_q;
  logic             bcd_q, live_q, sq_hi_q;
  logic             gate_paused, edge_mode;
  logic [CNT_W-1:0] dec_val, sq_hi_load, sq_lo_load;

  assign gate_paused = (mode_q == M_TC_INT) || (mode_q == M_SW_STB);
  assign edge_mode   = (mode_q == M_ONESHOT) || (mode_q == M_RATE) ||
                       (mode_q == M_SQUARE)  || (mode_q == M_HW_STB);

  assign run_o     = live_q & tick_i & (gate_i | ~gate_paused);
  assign restart_o = live_q & rise_i & edge_mode;
  assign at_one_o  = (cnt_q == ONE);

  assign dec_val    = bcd_q ? bcd_dec(cnt_q) : cnt_q - ONE;
  // high phase runs from N rounded up to even, low phase from N rounded down
  assign sq_hi_load = init_q + CNT_W'(init_q[0]);
  assign sq_lo_load = {init_q[CNT_W-1:1], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      init_q  <= '0;
      mode_q  <= M_TC_INT;
      bcd_q   <= 1'b0;
      live_q  <= 1'b0;
      sq_hi_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= (load_mode_i == M_SQUARE) ? load_val_i + CNT_W'(load_val_i[0])
                                           : load_val_i;
      init_q  <= load_val_i;
      mode_q  <= load_mode_i;
      bcd_q   <= load_bcd_i & (load_mode_i != M_SQUARE);
      live_q  <= 1'b1;
      sq_hi_q <= 1'b1;
    end else if (restart_o) begin
      cnt_q   <= (mode_q == M_SQUARE) ? sq_hi_load : init_q;
      sq_hi_q <= 1'b1;
    end else if (run_o) begin
      unique case (mode_q)
        M_RATE:   cnt_q <= at_one_o ? init_q : dec_val;
        M_SQUARE: begin
          if (cnt_q == TWO) begin
            cnt_q   <= sq_hi_q ? sq_lo_load : sq_hi_load;
            sq_hi_q <= ~sq_hi_q;
          end else begin
            cnt_q <= cnt_q - TWO;
          end
        end
        default:  cnt_q <= dec_val;
      endcase
    end
  end

  assign cnt_o   = cnt_q;
  assign mode_o  = mode_q;
  assign bcd_o   = bcd_q;
  assign live_o  = live_q;
  assign sq_hi_o = sq_hi_q;
endmodule

// File: rtl/pit_out_gen.sv
module pit_out_gen
  import pit_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pit_mode_e mode_i,
  input  logic      load_i,
  input  pit_mode_e load_mode_i,
  input  logic      restart_i,
  input  logic      run_i,
  input  logic      at_one_i,
  input  logic      sq_hi_i,
  output logic      out_o
);
  logic out_q, fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= 1'b0;
      fired_q <= 1'b0;
    end else if (load_i) begin
      out_q   <= (load_mode_i == M_ONESHOT);
      fired_q <= 1'b0;
    end else if (restart_i) begin
      out_q   <= (mode_i == M_ONESHOT);
      fired_q <= 1'b0;
    end else if (run_i) begin
      unique case (mode_i)
        M_TC_INT:  if (at_one_i) out_q <= 1'b1;
        M_ONESHOT: if (at_one_i) out_q <= 1'b0;
        M_RATE:    out_q <= at_one_i;
        M_SW_STB, M_HW_STB: begin
          out_q <= at_one_i & ~fired_q;
          if (at_one_i) fired_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign out_o = (mode_i == M_SQUARE) ? sq_hi_i : out_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                gate_i,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    load_count_i,
  input  logic [MODE_W-1:0]   load_mode_i,
  input  logic                load_bcd_i,
  output logic [CNT_W-1:0]    count_o,
  output logic                out_o
);
  pit_mode_e load_mode_w, mode_w;
  logic      rise_w, bcd_w, live_w, sq_hi_w, run_w, restart_w, at_one_w;

  assign load_mode_w = norm_mode(load_mode_i);

  pit_edge_det u_gate_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (gate_i),
    .rise_o (rise_w)
  );

  pit_count_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .gate_i      (gate_i),
    .rise_i      (rise_w),
    .load_i      (load_i),
    .load_val_i  (load_count_i),
    .load_mode_i (load_mode_w),
    .load_bcd_i  (load_bcd_i),
    .cnt_o       (count_o),
    .mode_o      (mode_w),
    .bcd_o       (bcd_w),
    .live_o      (live_w),
    .sq_hi_o     (sq_hi_w),
    .run_o       (run_w),
    .restart_o   (restart_w),
    .at_one_o    (at_one_w)
  );

  pit_out_gen u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_w),
    .load_i      (load_i),
    .load_mode_i (load_mode_w),
    .restart_i   (restart_w),
    .run_i       (run_w),
    .at_one_i    (at_one_w),
    .sq_hi_i     (sq_hi_w),
    .out_o       (out_o)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              gate_i,
  input logic              load_i,
  input logic [MODE_W-1:0] load_mode_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              out_o,
  input pit_mode_e         mode_w,
  input logic              bcd_w,
  input logic              live_w
);
  assert_int_low_on_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && norm_mode(load_mode_i) == M_TC_INT |=> !out_o);

  assert_int_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_w && mode_w == M_TC_INT && out_o && !load_i |=> out_o);

  assert_oneshot_low_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w == M_ONESHOT && !out_o && !load_i && !$rose(gate_i) |=> !out_o);

  assert_square_high_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && norm_mode(load_mode_i) == M_SQUARE |=> out_o);

  assert_strobe_single_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_w && mode_w == M_SW_STB && out_o && tick_i && gate_i && !load_i |=> !out_o);

  assert_count_holds_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !tick_i && !$rose(gate_i) |=> $stable(count_o));

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    assert_bcd_digit_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_w && bcd_w && mode_w != M_SQUARE |-> count_o[4*i +: 4] <= 4'd9);
  end
endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .gate_i      (gate_i),
  .load_i      (load_i),
  .load_mode_i (load_mode_i),
  .count_o     (count_o),
  .out_o       (out_o),
  .mode_w      (mode_w),
  .bcd_w       (bcd_w),
  .live_w      (live_w)
);

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0, gate = 1'b0, ld = 1'b0, lbcd = 1'b0;
  logic [15:0] lval = '0;
  logic [2:0]  lmode = '0;
  logic [15:0] count_o;
  logic        out_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_live = 0, m_bcd = 0, m_gprev = 0;
  logic [15:0] m_n = '0;
  int          m_mode = 0;
  longint      m_d = 0;

  always #4 clk = ~clk;

  pit_channel dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .gate_i(gate),
    .load_i(ld), .load_count_i(lval), .load_mode_i(lmode), .load_bcd_i(lbcd),
    .count_o(count_o), .out_o(out_o)
  );

  function automatic longint from_bcd(logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  function automatic logic [15:0] to_bcd(longint v);
    return {4'(v/1000), 4'((v/100)%10), 4'((v/10)%10), 4'(v%10)};
  endfunction

  task automatic expect_now(output logic [15:0] ec, output bit eo);
    longint modv, n, neff, p, h2, hv, lv, c;
    bit b;
    ec = '0; eo = 0;
    if (m_live) begin
      b    = m_bcd && (m_mode != 3);
      modv = b ? 10000 : 65536;
      n    = b ? from_bcd(m_n) : longint'(m_n);
      neff = (n == 0) ? modv : n;
      case (m_mode)
        2: begin
          p  = m_d % neff;
          c  = (neff - p) % modv;
          ec = b ? to_bcd(c) : 16'(c);
          eo = (m_d != 0) && (p == 0);
        end
        3: begin
          p  = m_d % neff;
          h2 = (neff + 1) / 2;
          hv = neff + (neff % 2);
          lv = neff - (neff % 2);
          if (p < h2) begin ec = 16'(hv - 2*p);        eo = 1; end
          else        begin ec = 16'(lv - 2*(p - h2)); eo = 0; end
        end
        default: begin
          c  = (neff - (m_d % modv) + modv) % modv;
          ec = b ? to_bcd(c) : 16'(c);
          case (m_mode)
            0:       eo = (m_d >= neff);
            1:       eo = (m_d < neff);
            default: eo = (m_d == neff);
          endcase
        end
      endcase
    end
  endtask

  task automatic compare(input string req);
    logic [15:0] ec;
    bit eo;
    expect_now(ec, eo);
    n_cmp++;
    if (count_o !== ec) begin
      n_bad++;
      $display("FAIL %s count got %h expected %h (d=%0d)", req, count_o, ec, m_d);
    end
    n_cmp++;
    if (out_o !== eo) begin
      n_bad++;
      $display("FAIL %s out got %b expected %b (d=%0d)", req, out_o, eo, m_d);
    end
  endtask

  // one clock: model mirrors the edge, outputs sampled at the falling edge
  task automatic step(input string req);
    bit rise;
    @(posedge clk);
    rise = gate && !m_gprev;
    m_gprev = gate;
    if (ld) begin
      m_live = 1; m_n = lval; m_bcd = lbcd; m_d = 0;
      m_mode = (lmode >= 6) ? int'(lmode) - 4 : int'(lmode);
    end else if (m_live && rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
      m_d = 0;
    end else if (m_live && tick && (gate || !(m_mode == 0 || m_mode == 4))) begin
      m_d++;
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic run(input int n, input bit tk, input bit gt, input string req);
    for (int i = 0; i < n; i++) begin
      tick = tk; gate = gt;
      step(req);
    end
  endtask

  task automatic load(input logic [15:0] v, input logic [2:0] m, input bit b,
                      input bit tk, input bit gt, input string req);
    ld = 1; lval = v; lmode = m; lbcd = b; tick = tk; gate = gt;
    step(req);
    ld = 0;
  endtask

  task automatic t_reset;
    compare("R1");
    run(3, 1, 1, "R1");
    run(2, 1, 0, "R1");
  endtask

  task automatic t_mode0;
    load(16'd5, 3'd0, 0, 0, 1, "R4");
    run(4, 1, 1, "R4");
    run(3, 1, 0, "R4");
    run(4, 1, 1, "R4");
    load(16'd4, 3'd0, 0, 0, 1, "R4");
    run(6, 1, 1, "R4");
  endtask

  task automatic t_mode1;
    load(16'd3, 3'd1, 0, 0, 0, "R5");
    run(2, 1, 0, "R5");
    run(1, 1, 1, "R5");
    run(5, 1, 1, "R5");
    run(2, 1, 0, "R5");
    load(16'd4, 3'd1, 0, 0, 0, "R5");
    run(6, 1, 0, "R5");
  endtask

  task automatic t_mode2;
    load(16'd4, 3'd2, 0, 0, 1, "R6");
    run(10, 1, 1, "R6");
    run(2, 0, 1, "R6");
    load(16'd5, 3'd2, 0, 0, 0, "R6");
    run(7, 1, 0, "R6");
    run(1, 1, 1, "R6");
    run(12, 1, 1, "R6");
  endtask

  task automatic t_mode3;
    load(16'd6, 3'd3, 0, 0, 1, "R7");
    run(14, 1, 1, "R7");
    load(16'd5, 3'd3, 0, 0, 1, "R7");
    run(12, 1, 1, "R7");
    load(16'd7, 3'd3, 1, 0, 1, "R7");
    run(10, 1, 1, "R7");
  endtask

  task automatic t_mode4;
    load(16'd3, 3'd4, 0, 0, 1, "R8");
    run(3, 1, 1, "R8");
    run(2, 1, 0, "R8");
    run(3, 1, 1, "R8");
  endtask

  task automatic t_mode5;
    load(16'd4, 3'd5, 0, 0, 0, "R9");
    run(5, 1, 0, "R9");
    run(1, 0, 1, "R9");
    run(6, 1, 1, "R9");
  endtask

  task automatic t_zero;
    load(16'h0000, 3'd0, 0, 0, 1, "R3");
    run(65538, 1, 1, "R3");
    load(16'h0000, 3'd4, 1, 0, 1, "R3");
    run(10002, 1, 1, "R3");
  endtask

  task automatic t_bcd_borrow;
    load(16'h0100, 3'd1, 1, 0, 0, "R11");
    run(5, 1, 0, "R11");
    load(16'h1000, 3'd2, 1, 0, 0, "R11");
    run(3, 1, 0, "R11");
  endtask

  task automatic t_mode_alias;
    load(16'd3, 3'd6, 0, 0, 1, "R2");
    run(8, 1, 1, "R2");
    load(16'd4, 3'd7, 0, 0, 1, "R2");
    run(8, 1, 1, "R2");
  endtask

  task automatic t_priority;
    load(16'd9, 3'd5, 0, 1, 0, "R10");
    run(3, 1, 0, "R10");
    load(16'd6, 3'd5, 0, 1, 1, "R10");
    run(4, 0, 1, "R10");
    run(2, 1, 1, "R10");
    load(16'd8, 3'd0, 0, 1, 1, "R10");
    run(3, 0, 0, "R10");
    run(2, 1, 1, "R10");
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_bcd_borrow();
    t_mode_alias();
    t_priority();
    t_zero();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule